// File: doc/BRIEF.md
# PLL holdover and lock-detect controller

This block supervises a reference-locked loop. Once per phase-detector cycle it receives a strobe together with the measured magnitude of the phase error between the reference and feedback edges. From a run of consecutive comparisons inside a programmed window it raises a digital lock-detect flag. It also runs a two-state machine that moves the loop between normal tracking and holdover.

The block drives a tuning DAC code. While tracking, the code is reloaded from a sampled tune-voltage code on a slowed update strobe, which is the phase-detector strobe divided by a programmable divisor. In holdover the code is either frozen at the last tracked value or replaced by a manual value. The applied code is compared against a low rail threshold and a high rail threshold, each programmed in coarse steps. A crossing raises a one-cycle clock-switch event, and that event forces holdover when holdover is enabled. Holdover ends after a programmed count of consecutive in-window comparisons.

Top module: `pll_hold_ctrl`

## Requirements
- R1: On each strobe with phase_err < win_size, the lock run count increments. lock_det is 1 after the strobe at which the run length reaches lock_lim. A run length of 1 or more satisfies lock_lim 0.
- R2: A strobe with phase_err >= win_size, including equality, clears the run and sets lock_det to 0 on the next cycle.
- R3: Cycles without pd_strobe leave lock_det unchanged.
- R4: Counted from reset, the internal DAC update fires on every max(dac_div,1)-th strobe, so a dac_div of 0 behaves as 1.
- R5: While tracking, an update loads tune_code into dac_code at the clock edge of that strobe.
- R6: In holdover with man_en = 1, dac_code equals man_code from the same cycle.
- R7: In holdover with man_en = 0, dac_code stays at the last tracked code, and tune_code and strobes have no effect on it.
- R8: With rail_en = 1, dac_code <= low_trip*16 counts as a low trip. clk_switch is 1 for exactly one cycle, the first cycle in which a trip condition holds.
- R9: With rail_en = 1, dac_code >= 1023 - high_trip*16 counts as a high trip, with the same one-cycle pulse.
- R10: With rail_en = 0, clk_switch stays 0 for any dac_code.
- R11: A clk_switch while hold_en = 1 sets holdover on the next cycle. With hold_en = 0, holdover stays 0.
- R12: In holdover, exit_lim consecutive in-window strobes end holdover one cycle after the last of them. An out-of-window strobe restarts the count, and the count is zero on entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pd_strobe | input | 1 | One pulse per phase-detector cycle |
| phase_err | input | 8 | Measured phase-error magnitude |
| win_size | input | 8 | In-window limit (error must be strictly below) |
| lock_lim | input | 8 | Run length needed for lock detect |
| exit_lim | input | 8 | Run length needed to leave holdover |
| dac_div | input | 8 | Update divisor, 0 treated as 1 |
| man_en | input | 1 | Manual DAC value in holdover |
| man_code | input | 10 | Manual DAC value |
| tune_code | input | 10 | Sampled tune-voltage code |
| rail_en | input | 1 | Enables rail-trip checks |
| low_trip | input | 6 | Low threshold in 16-code steps above zero |
| high_trip | input | 6 | High threshold in 16-code steps below 1023 |
| hold_en | input | 1 | Allows a switch event to enter holdover |
| lock_det | output | 1 | Digital lock detect |
| holdover | output | 1 | Holdover active |
| clk_switch | output | 1 | One-cycle clock-switch event |
| dac_code | output | 10 | DAC code currently applied (readback) |

## Verification
Lock detect is swept over limits 0 to 5 with runs of in-window strobes, broken by an error equal to the window, which separates strict from inclusive comparison and shows the off-by-one point of each limit. The divisor is swept from 0 to 4 with a fresh tune code on every strobe, so the code seen at the output tells the update phase and the zero-as-one rule apart. Rail trips are driven one code either side of each threshold, with and without the enables. A holdover pass checks the frozen and manual codes, and an exit run interrupted once shows that the exit count restarts.

// File: rtl/phl_pkg.sv
package phl_pkg;
  typedef enum logic {ST_TRACK = 1'b0, ST_HOLD = 1'b1} hold_state_t;
endpackage

// File: rtl/phl_run_cnt.sv
module phl_run_cnt #(
  parameter int PW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pd_strobe,
  input  logic [PW-1:0] phase_err,
  input  logic [PW-1:0] win_size,
  input  logic [CW-1:0] lim,
  output logic          done
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          done_q, done_d;
  logic          in_win;

  assign in_win  = phase_err < win_size;
  assign cnt_inc = (cnt_q == CMAX) ? cnt_q : cnt_q + CW'(1);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (clr) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (pd_strobe) begin
      if (in_win) begin
        cnt_d  = cnt_inc;
        done_d = (cnt_inc >= lim);
      end else begin
        cnt_d  = '0;
        done_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  p_out_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_strobe && (phase_err >= win_size)) |=> !done);
  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_strobe && !clr) |=> $stable(done));
  p_rise_in_win_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pd_strobe && (phase_err < win_size)));
endmodule

// File: rtl/phl_upd_div.sv
module phl_upd_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_strobe,
  input  logic [DW-1:0] dac_div,
  output logic          upd
);
  logic [DW-1:0] cnt_q, cnt_d, eff_div;

  assign eff_div = (dac_div == '0) ? DW'(1) : dac_div;
  assign upd     = pd_strobe && (cnt_q >= eff_div - DW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (pd_strobe) cnt_d = upd ? '0 : cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_upd_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> pd_strobe);
  p_div_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_strobe && (dac_div <= DW'(1))) |-> upd);
endmodule

// File: rtl/phl_rail_trip.sv
module phl_rail_trip #(
  parameter int AW    = 10,
  parameter int TW    = 6,
  parameter int SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rail_en,
  input  logic [AW-1:0] dac_code,
  input  logic [TW-1:0] low_trip,
  input  logic [TW-1:0] high_trip,
  output logic          clk_switch
);
  localparam int XW = AW + TW + SHIFT + 1;
  localparam logic [XW-1:0] CODE_MAX = XW'((1 << AW) - 1);

  logic [XW-1:0] code_x, low_x, high_x;
  logic          trip_now, trip_q;

  assign code_x   = XW'(dac_code);
  assign low_x    = XW'(low_trip) << SHIFT;
  assign high_x   = XW'(high_trip) << SHIFT;
  assign trip_now = rail_en && ((code_x <= low_x) || (code_x + high_x >= CODE_MAX));
  assign clk_switch = trip_now && !trip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= trip_now;
  end

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_switch |=> !clk_switch);
  p_no_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_en |-> !clk_switch);
endmodule

// File: rtl/pll_hold_ctrl.sv
module pll_hold_ctrl #(
  parameter int PW    = 8,
  parameter int CW    = 8,
  parameter int DW    = 8,
  parameter int AW    = 10,
  parameter int TW    = 6,
  parameter int SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_strobe,
  input  logic [PW-1:0] phase_err,
  input  logic [PW-1:0] win_size,
  input  logic [CW-1:0] lock_lim,
  input  logic [CW-1:0] exit_lim,
  input  logic [DW-1:0] dac_div,
  input  logic          man_en,
  input  logic [AW-1:0] man_code,
  input  logic [AW-1:0] tune_code,
  input  logic          rail_en,
  input  logic [TW-1:0] low_trip,
  input  logic [TW-1:0] high_trip,
  input  logic          hold_en,
  output logic          lock_det,
  output logic          holdover,
  output logic          clk_switch,
  output logic [AW-1:0] dac_code
);
  import phl_pkg::*;

  localparam logic [AW-1:0] CODE_MID = AW'(1 << (AW - 1));

  logic [1:0]    rst_sync;
  logic          rst_n_i;
  hold_state_t   state_q, state_d;
  logic [AW-1:0] track_q, track_d;
  logic          upd, exit_done, switch_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  phl_run_cnt #(.PW(PW), .CW(CW)) u_lock (
    .clk(clk), .rst_n(rst_n_i), .clr(1'b0), .pd_strobe(pd_strobe),
    .phase_err(phase_err), .win_size(win_size), .lim(lock_lim), .done(lock_det));

  phl_run_cnt #(.PW(PW), .CW(CW)) u_exit (
    .clk(clk), .rst_n(rst_n_i), .clr(state_q != ST_HOLD), .pd_strobe(pd_strobe),
    .phase_err(phase_err), .win_size(win_size), .lim(exit_lim), .done(exit_done));

  phl_upd_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n_i), .pd_strobe(pd_strobe), .dac_div(dac_div), .upd(upd));

  phl_rail_trip #(.AW(AW), .TW(TW), .SHIFT(SHIFT)) u_rail (
    .clk(clk), .rst_n(rst_n_i), .rail_en(rail_en), .dac_code(dac_code),
    .low_trip(low_trip), .high_trip(high_trip), .clk_switch(switch_ev));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TRACK: if (switch_ev && hold_en) state_d = ST_HOLD;
      ST_HOLD:  if (exit_done)            state_d = ST_TRACK;
      default:                            state_d = ST_TRACK;
    endcase
  end

  always_comb begin
    track_d = track_q;
    if ((state_q == ST_TRACK) && upd) track_d = tune_code;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_TRACK;
      track_q <= CODE_MID;
    end else begin
      state_q <= state_d;
      track_q <= track_d;
    end
  end

  assign holdover   = (state_q == ST_HOLD);
  assign dac_code   = (holdover && man_en) ? man_code : track_q;
  assign clk_switch = switch_ev;

  p_enter_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (clk_switch && hold_en) |=> holdover);
  p_exit_by_count_r12: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(holdover) |-> $past(exit_done));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (holdover && !man_en && $past(holdover && !man_en)) |-> $stable(dac_code));
  p_track_load_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd && !holdover) |=> ((holdover && man_en) || (dac_code == $past(tune_code))));
endmodule

// File: tb/pll_hold_ctrl_test.sv
module pll_hold_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pd_strobe;
  logic [7:0] phase_err, win_size, lock_lim, exit_lim, dac_div;
  logic       man_en, rail_en, hold_en;
  logic [9:0] man_code, tune_code;
  logic [5:0] low_trip, high_trip;
  logic       lock_det, holdover, clk_switch;
  logic [9:0] dac_code;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pll_hold_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pd_strobe(pd_strobe), .phase_err(phase_err),
    .win_size(win_size), .lock_lim(lock_lim), .exit_lim(exit_lim), .dac_div(dac_div),
    .man_en(man_en), .man_code(man_code), .tune_code(tune_code), .rail_en(rail_en),
    .low_trip(low_trip), .high_trip(high_trip), .hold_en(hold_en),
    .lock_det(lock_det), .holdover(holdover), .clk_switch(clk_switch), .dac_code(dac_code));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe(input int err, input int tune);
    pd_strobe = 1'b1;
    phase_err = 8'(err);
    tune_code = 10'(tune);
    @(negedge clk);
    pd_strobe = 1'b0;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pd_strobe = 1'b0; phase_err = '0; win_size = 8'd20;
    lock_lim = 8'd3; exit_lim = 8'd3; dac_div = 8'd1; man_en = 1'b0;
    man_code = '0; tune_code = 10'd512; rail_en = 1'b0; low_trip = 6'd4;
    high_trip = 6'd2; hold_en = 1'b0;
    do_reset();
    chk("reset lock_det R1", int'(lock_det), 0);
    chk("reset holdover R11", int'(holdover), 0);
    chk("reset clk_switch R10", int'(clk_switch), 0);
    chk("reset dac_code R5", int'(dac_code), 512);

    // R1 R2 R3: lock limit sweep
    for (int lim = 0; lim <= 5; lim++) begin
      lock_lim = 8'(lim);
      strobe(20, 512);
      chk("R2 err==win clears lock", int'(lock_det), 0);
      for (int k = 1; k <= lim + 1; k++) begin
        strobe(19, 512);
        chk("R1 lock after run", int'(lock_det), (k >= lim) ? 1 : 0);
      end
      repeat (4) @(negedge clk);
      chk("R3 idle keeps lock", int'(lock_det), 1);
      strobe(200, 512);
      chk("R2 big err clears lock", int'(lock_det), 0);
      repeat (3) @(negedge clk);
      chk("R3 idle keeps unlock", int'(lock_det), 0);
    end

    // R4 R5: divider sweep
    for (int d = 0; d <= 4; d++) begin
      int eff;
      int exp_code;
      eff = (d == 0) ? 1 : d;
      dac_div = 8'(d);
      do_reset();
      exp_code = 512;
      for (int s = 1; s <= 12; s++) begin
        strobe(5, 100 + s);
        if (s % eff == 0) exp_code = 100 + s;
        chk("R4 R5 update phase", int'(dac_code), exp_code);
      end
    end

    // R8 R11 R6 R7 R12: trip into holdover, then exit
    dac_div = 8'd1;
    do_reset();
    rail_en = 1'b1; hold_en = 1'b1; low_trip = 6'd4; high_trip = 6'd2;
    strobe(5, 300);
    chk("R8 no trip at 300", int'(clk_switch), 0);
    strobe(5, 50);
    chk("R8 low trip pulse", int'(clk_switch), 1);
    chk("R11 not yet holdover", int'(holdover), 0);
    @(negedge clk);
    chk("R8 pulse is one cycle", int'(clk_switch), 0);
    chk("R11 holdover entered", int'(holdover), 1);
    strobe(30, 700);
    strobe(30, 701);
    chk("R7 frozen code", int'(dac_code), 50);
    man_code = 10'd40; man_en = 1'b1;
    #1;
    chk("R6 manual code", int'(dac_code), 40);
    @(negedge clk);
    man_en = 1'b0;
    #1;
    chk("R7 back to frozen", int'(dac_code), 50);
    @(negedge clk);
    exit_lim = 8'd3;
    strobe(5, 700);
    strobe(5, 700);
    strobe(30, 700);
    strobe(5, 700);
    strobe(5, 700);
    repeat (2) @(negedge clk);
    chk("R12 restart keeps holdover", int'(holdover), 1);
    strobe(5, 700);
    @(negedge clk);
    chk("R12 exit after run", int'(holdover), 0);
    chk("R12 exit restores tracked", int'(dac_code), 50);
    strobe(5, 700);
    chk("R5 tracking resumes", int'(dac_code), 700);

    // R9 R11: high trip with holdover disabled, thresholds at boundary
    hold_en = 1'b0;
    strobe(5, 990);
    chk("R9 below high threshold", int'(clk_switch), 0);
    strobe(5, 991);
    chk("R9 high trip pulse", int'(clk_switch), 1);
    @(negedge clk);
    chk("R9 pulse ends", int'(clk_switch), 0);
    chk("R11 no holdover when disabled", int'(holdover), 0);
    strobe(5, 500);
    strobe(5, 65);
    chk("R8 above low threshold", int'(clk_switch), 0);
    strobe(5, 64);
    chk("R8 low threshold inclusive", int'(clk_switch), 1);
    strobe(5, 500);

    // R10: rail checks disabled
    rail_en = 1'b0;
    strobe(5, 10);
    chk("R10 low ignored", int'(clk_switch), 0);
    strobe(5, 1015);
    chk("R10 high ignored", int'(clk_switch), 0);
    @(negedge clk);
    chk("R10 no holdover", int'(holdover), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule